// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block collects ninety-six level-sensitive interrupt sources, arranged as three 32-bit groups (main low, main high and general-purpose pins), and presents them to one CPU as a single interrupt line plus an encoded vector that names the winning source. Each group latches its sources into a cause word, and a per-group mask word decides which cause bits take part. The pin group does not reach the CPU on its own. It is folded into four summary bits of the high cause word, and those bits are then masked like any other high bit.

Software talks to the block over a simple 32-bit bus with a write strobe, a window select and a byte offset. The main window carries the low and high cause and mask words and a select-cause word. The pin window carries the pin cause and mask words. Reads are combinational from the current state. Software clears cause bits by writing zeros to them. A source that is still asserted sets its bit again at once.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset all cause words read 0, the low and pin masks read 0, the high mask reads 0x0F000000, irq_o is 0 and vector_o is 0.
- R2: A source held high across a rising clock edge sets its cause bit at that edge. The bit stays set after the source drops until software clears it.
- R3: A write to a cause word (main low at 0x04, main high at 0x0C, pin at window 1 offset 0x08) clears each bit written as 0 and leaves each bit written as 1 unchanged. A bit whose source is still high stays set.
- R4: Mask words are read/write at main 0x14 (low), main 0x1C (high) and pin-window 0x0C (pin). irq_o is 1 exactly when some bit is set in both the low cause and the low mask, or in both the high cause view and the high mask.
- R5: High cause bit 24+k (k = 0..3) reads 1 when any bit of pin cause AND pin mask in bits 8k..8k+7 is set. The external high-source inputs at bits 24..27 are ignored.
- R6: The select-cause word at main 0x24 returns the low cause with bit 30 cleared when some unmasked low bit is pending. Otherwise it returns the high cause view with bit 30 set.
- R7: vector_o = group*32 + index of the highest set masked bit. The group is 0 (low) when any unmasked low bit is pending, else 2 (pin) when any unmasked bit among high bits 24..27 is set, else 1 (high).
- R8: vector_o is 0 whenever irq_o is 0.
- R9: Reads of unmapped offsets in either window return 0. Writes to unmapped offsets, and writes to the select-cause word, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_low_i | input | 32 | Level sources 0..31 |
| src_high_i | input | 32 | Level sources 32..63 (bits 24..27 unused) |
| src_pin_i | input | 32 | Level sources 64..95 |
| bus_wr_i | input | 1 | Write strobe, applied at the clock edge |
| bus_win_i | input | 1 | Window select: 0 main, 1 pin |
| bus_addr_i | input | 8 | Byte offset within the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed word (combinational) |
| irq_o | output | 1 | CPU interrupt request |
| vector_o | output | 7 | Encoded source: group in bits 6:5, bit index in bits 4:0 |

## Verification
The assertions assume that sources and bus fields are stable around the clock edge and that every source is low while reset is applied. The source-latching property also relies on this, because it looks one cycle into the past. The bench changes every input only on the falling edge and holds all sources at zero through reset, so both assumptions always hold. The pin-precedence and cascade properties also assume that the pin mask is the only thing gating the summary bits. The stimulus exercises this by giving pin sources with the cascade bits masked and unmasked in the high mask.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned ADDR_W = 8;

  typedef enum logic [1:0] {
    GRP_LOW  = 2'd0,
    GRP_HIGH = 2'd1,
    GRP_PIN  = 2'd2
  } grp_e;

  localparam int unsigned N_GRP = 3;

  // main window
  localparam logic [ADDR_W-1:0] OFF_LOW_CAUSE  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_HIGH_CAUSE = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_LOW_MASK   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_HIGH_MASK  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_SEL_CAUSE  = 8'h24;
  // pin window
  localparam logic [ADDR_W-1:0] OFF_PIN_CAUSE  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_PIN_MASK   = 8'h0C;
endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int unsigned   W    = 32,
  parameter logic [W-1:0]  LIVE = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] keep_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] cause_q;
  logic [W-1:0] held;

  assign held = clr_we_i ? (cause_q & keep_i) : cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= (held | src_i) & LIVE;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned  W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= RST_VAL;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/irq_msb_enc.sv
module irq_msb_enc #(
  parameter int unsigned W     = 32,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/irq_cascade.sv
module irq_cascade #(
  parameter int unsigned W      = 32,
  parameter int unsigned N      = 4,
  localparam int unsigned SLICE = W / N
) (
  input  logic [W-1:0] pin_m_i,
  output logic [N-1:0] sum_o
);
  for (genvar k = 0; k < N; k++) begin : g_slice
    assign sum_o[k] = |pin_m_i[k*SLICE +: SLICE];
  end
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned GRP_W    = 32,
  parameter int unsigned CASC_LSB = 24,
  parameter int unsigned CASC_N   = 4,
  parameter int unsigned SEL_FLAG = 30,
  localparam int unsigned IDX_W   = $clog2(GRP_W),
  localparam int unsigned VEC_W   = 2 + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GRP_W-1:0]  src_low_i,
  input  logic [GRP_W-1:0]  src_high_i,
  input  logic [GRP_W-1:0]  src_pin_i,
  input  logic              bus_wr_i,
  input  logic              bus_win_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [GRP_W-1:0]  bus_wdata_i,
  output logic [GRP_W-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vector_o
);
  localparam logic [GRP_W-1:0] CASC_FIELD =
    {{(GRP_W-CASC_N){1'b0}}, {CASC_N{1'b1}}} << CASC_LSB;
  localparam logic [GRP_W-1:0] FLAG_BIT =
    {{(GRP_W-1){1'b0}}, 1'b1} << SEL_FLAG;

  logic [GRP_W-1:0] low_cause_q, high_cause_q, pin_cause_q;
  logic [GRP_W-1:0] low_mask_q, high_mask_q, pin_mask_q;
  logic [GRP_W-1:0] high_view, sel_word;
  logic [CASC_N-1:0] casc_sum;
  logic main_wr, pin_wr;
  logic we_low_c, we_high_c, we_pin_c, we_low_m, we_high_m, we_pin_m;

  // write decode
  assign main_wr   = bus_wr_i & ~bus_win_i;
  assign pin_wr    = bus_wr_i &  bus_win_i;
  assign we_low_c  = main_wr && (bus_addr_i == OFF_LOW_CAUSE);
  assign we_high_c = main_wr && (bus_addr_i == OFF_HIGH_CAUSE);
  assign we_low_m  = main_wr && (bus_addr_i == OFF_LOW_MASK);
  assign we_high_m = main_wr && (bus_addr_i == OFF_HIGH_MASK);
  assign we_pin_c  = pin_wr  && (bus_addr_i == OFF_PIN_CAUSE);
  assign we_pin_m  = pin_wr  && (bus_addr_i == OFF_PIN_MASK);

  irq_cause_reg #(.W(GRP_W)) u_low_cause (
    .clk_i, .rst_ni, .src_i(src_low_i), .clr_we_i(we_low_c),
    .keep_i(bus_wdata_i), .cause_o(low_cause_q));

  // cascade positions carry no storage; they are driven by the pin summary
  irq_cause_reg #(.W(GRP_W), .LIVE(~CASC_FIELD)) u_high_cause (
    .clk_i, .rst_ni, .src_i(src_high_i), .clr_we_i(we_high_c),
    .keep_i(bus_wdata_i), .cause_o(high_cause_q));

  irq_cause_reg #(.W(GRP_W)) u_pin_cause (
    .clk_i, .rst_ni, .src_i(src_pin_i), .clr_we_i(we_pin_c),
    .keep_i(bus_wdata_i), .cause_o(pin_cause_q));

  irq_mask_reg #(.W(GRP_W)) u_low_mask (
    .clk_i, .rst_ni, .we_i(we_low_m), .wdata_i(bus_wdata_i), .mask_o(low_mask_q));

  irq_mask_reg #(.W(GRP_W), .RST_VAL(CASC_FIELD)) u_high_mask (
    .clk_i, .rst_ni, .we_i(we_high_m), .wdata_i(bus_wdata_i), .mask_o(high_mask_q));

  irq_mask_reg #(.W(GRP_W)) u_pin_mask (
    .clk_i, .rst_ni, .we_i(we_pin_m), .wdata_i(bus_wdata_i), .mask_o(pin_mask_q));

  // pin group folds into the high word
  logic [GRP_W-1:0] grp_m [N_GRP];
  logic [N_GRP-1:0] grp_any;
  logic [IDX_W-1:0] grp_idx [N_GRP];

  irq_cascade #(.W(GRP_W), .N(CASC_N)) u_cascade (
    .pin_m_i(grp_m[GRP_PIN]), .sum_o(casc_sum));

  assign high_view = (high_cause_q & ~CASC_FIELD)
                   | ({{(GRP_W-CASC_N){1'b0}}, casc_sum} << CASC_LSB);

  assign grp_m[GRP_LOW]  = low_cause_q & low_mask_q;
  assign grp_m[GRP_HIGH] = high_view   & high_mask_q;
  assign grp_m[GRP_PIN]  = pin_cause_q & pin_mask_q;

  for (genvar g = 0; g < N_GRP; g++) begin : g_enc
    irq_msb_enc #(.W(GRP_W)) u_enc (
      .vec_i(grp_m[g]), .any_o(grp_any[g]), .idx_o(grp_idx[g]));
  end

  // winner selection: low, then cascaded pin, then high
  logic casc_hit;
  grp_e win_grp;
  logic [IDX_W-1:0] win_idx;

  assign casc_hit = |(grp_m[GRP_HIGH] & CASC_FIELD);

  always_comb begin
    win_grp = GRP_LOW;
    win_idx = '0;
    if (grp_any[GRP_LOW]) begin
      win_grp = GRP_LOW;
      win_idx = grp_idx[GRP_LOW];
    end else if (casc_hit && grp_any[GRP_PIN]) begin
      win_grp = GRP_PIN;
      win_idx = grp_idx[GRP_PIN];
    end else if (grp_any[GRP_HIGH]) begin
      win_grp = GRP_HIGH;
      win_idx = grp_idx[GRP_HIGH];
    end
  end

  assign irq_o    = grp_any[GRP_LOW] | grp_any[GRP_HIGH];
  assign vector_o = irq_o ? {win_grp, win_idx} : '0;

  assign sel_word = grp_any[GRP_LOW] ? (low_cause_q & ~FLAG_BIT)
                                     : (high_view | FLAG_BIT);

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (!bus_win_i) begin
      unique case (bus_addr_i)
        OFF_LOW_CAUSE:  bus_rdata_o = low_cause_q;
        OFF_HIGH_CAUSE: bus_rdata_o = high_view;
        OFF_LOW_MASK:   bus_rdata_o = low_mask_q;
        OFF_HIGH_MASK:  bus_rdata_o = high_mask_q;
        OFF_SEL_CAUSE:  bus_rdata_o = sel_word;
        default:        bus_rdata_o = '0;
      endcase
    end else begin
      unique case (bus_addr_i)
        OFF_PIN_CAUSE: bus_rdata_o = pin_cause_q;
        OFF_PIN_MASK:  bus_rdata_o = pin_mask_q;
        default:       bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/casc_irq_ctrl_chk.sv
module casc_irq_ctrl_chk #(
  parameter int unsigned GRP_W    = 32,
  parameter int unsigned CASC_LSB = 24,
  parameter int unsigned CASC_N   = 4,
  localparam int unsigned VEC_W   = 2 + $clog2(GRP_W)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [GRP_W-1:0] src_low_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vector_o,
  input logic [GRP_W-1:0] low_cause_q,
  input logic [GRP_W-1:0] low_mask_q,
  input logic [GRP_W-1:0] high_mask_q,
  input logic [GRP_W-1:0] high_view,
  input logic [GRP_W-1:0] pin_cause_q,
  input logic [GRP_W-1:0] pin_mask_q
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_HMASK_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (high_mask_q == ({{(GRP_W-CASC_N){1'b0}}, {CASC_N{1'b1}}} << CASC_LSB))); // R1

  AST_SRC_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> ((low_cause_q & $past(src_low_i)) == $past(src_low_i))); // R2

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((low_mask_q | high_mask_q) != '0)); // R4

  AST_CASC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_cause_q & pin_mask_q) == '0) |-> (high_view[CASC_LSB +: CASC_N] == '0)); // R5

  AST_GRP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vector_o[VEC_W-1 -: 2] != 2'd3)); // R7

  AST_PIN_BACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && vector_o[VEC_W-1 -: 2] == 2'd2) |-> ((pin_cause_q & pin_mask_q) != '0)); // R7

  AST_VEC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vector_o == '0)); // R8
endmodule

bind casc_irq_ctrl casc_irq_ctrl_chk #(
  .GRP_W(GRP_W), .CASC_LSB(CASC_LSB), .CASC_N(CASC_N)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_low_i(src_low_i),
  .irq_o(irq_o), .vector_o(vector_o),
  .low_cause_q(low_cause_q), .low_mask_q(low_mask_q),
  .high_mask_q(high_mask_q), .high_view(high_view),
  .pin_cause_q(pin_cause_q), .pin_mask_q(pin_mask_q)
);

// File: tb/casc_irq_ctrl_tb.sv
`timescale 1ns/1ps
module casc_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lo = '0, src_hi = '0, src_pn = '0;
  logic        bus_wr = 1'b0, bus_win = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [6:0]  vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  casc_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .src_low_i(src_lo), .src_high_i(src_hi), .src_pin_i(src_pn),
    .bus_wr_i(bus_wr), .bus_win_i(bus_win), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .vector_o(vec));

  typedef struct packed {
    logic [31:0] lo, hi, pn, lm, hm, pm;
    logic        irq;
    logic [6:0]  vec;
  } vec_t;

  localparam int N_VEC = 11;
  localparam vec_t TBL [N_VEC] = '{
    '{32'h00000001, 32'h0, 32'h0, 32'hFFFFFFFF, 32'h0F000000, 32'h0, 1'b1, 7'd0},
    '{32'h80000010, 32'h0, 32'h0, 32'h00000010, 32'h0F000000, 32'h0, 1'b1, 7'd4},
    '{32'h0, 32'h00010002, 32'h0, 32'h0, 32'hFFFFFFFF, 32'h0, 1'b1, 7'd48},
    '{32'h0, 32'h80000000, 32'h00000100, 32'h0, 32'h0F000000, 32'hFFFFFFFF, 1'b1, 7'd72},
    '{32'h0, 32'h80000000, 32'h00000100, 32'h0, 32'h8F000000, 32'hFFFFFFFF, 1'b1, 7'd72},
    '{32'h0, 32'h80000000, 32'h00000100, 32'h0, 32'h80000000, 32'hFFFFFFFF, 1'b1, 7'd63},
    '{32'h00000002, 32'h80000000, 32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 7'd1},
    '{32'h0, 32'h0, 32'h80000001, 32'h0, 32'h0F000000, 32'h00000001, 1'b1, 7'd64},
    '{32'h0, 32'h0, 32'h00000001, 32'h0, 32'h0F000000, 32'h0, 1'b0, 7'd0},
    '{32'h0, 32'h0F000000, 32'h0, 32'h0, 32'hFFFFFFFF, 32'h0, 1'b0, 7'd0},
    '{32'h40000000, 32'h0, 32'h0, 32'h0, 32'h0F000000, 32'h0, 1'b0, 7'd0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic win, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_win = win; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic win, input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_win = win; bus_addr = a;
    #1;
    check(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] pn);
    @(negedge clk);
    src_lo = lo; src_hi = hi; src_pn = pn;
    @(negedge clk);
    src_lo = '0; src_hi = '0; src_pn = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd_chk(0, 8'h04, 32'h0, "R1 low cause");
    rd_chk(0, 8'h0C, 32'h0, "R1 high cause");
    rd_chk(0, 8'h14, 32'h0, "R1 low mask");
    rd_chk(0, 8'h1C, 32'h0F000000, "R1 high mask");
    rd_chk(1, 8'h08, 32'h0, "R1 pin cause");
    rd_chk(1, 8'h0C, 32'h0, "R1 pin mask");
    check(irq === 1'b0, "R1 irq", {31'h0, irq}, 32'h0);
    check(vec === 7'h0, "R1 vector", {25'h0, vec}, 32'h0);

    // table walk: R2 R4 R5 R7 R8
    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk);
      src_lo = TBL[i].lo; src_hi = TBL[i].hi; src_pn = TBL[i].pn;
      wr(0, 8'h14, TBL[i].lm);
      wr(0, 8'h1C, TBL[i].hm);
      wr(1, 8'h0C, TBL[i].pm);
      src_lo = '0; src_hi = '0; src_pn = '0;
      @(negedge clk);
      check(irq === TBL[i].irq, "R4 R2 irq from table", {31'h0, irq}, {31'h0, TBL[i].irq});
      check(vec === TBL[i].vec, "R7 R8 vector from table", {25'h0, vec}, {25'h0, TBL[i].vec});
      wr(0, 8'h04, 32'h0);
      wr(0, 8'h0C, 32'h0);
      wr(1, 8'h08, 32'h0);
      check(irq === 1'b0, "R3 irq after clearing", {31'h0, irq}, 32'h0);
    end

    // R3 write-0 clears, write-1 keeps, held level survives
    pulse(32'h3, 32'h0, 32'h0);
    wr(0, 8'h04, 32'hFFFFFFFE);
    rd_chk(0, 8'h04, 32'h00000002, "R3 partial clear");
    src_lo = 32'h2;
    wr(0, 8'h04, 32'h0);
    rd_chk(0, 8'h04, 32'h00000002, "R3 held source survives clear");
    src_lo = 32'h0;
    wr(0, 8'h04, 32'h0);
    rd_chk(0, 8'h04, 32'h0, "R3 clear after drop");

    // R6 select cause, low side
    pulse(32'h40000001, 32'h0, 32'h0);
    wr(0, 8'h14, 32'h00000001);
    rd_chk(0, 8'h24, 32'h00000001, "R6 select low with flag clear");
    wr(0, 8'h04, 32'h0);

    // R6 high side with R5 cascade bit
    pulse(32'h0, 32'h00000005, 32'h00000001);
    wr(1, 8'h0C, 32'h00000001);
    rd_chk(0, 8'h24, 32'h41000005, "R6 select high with flag set");
    rd_chk(0, 8'h0C, 32'h01000005, "R5 summary bit 24");
    wr(1, 8'h08, 32'hFFFFFFFE);
    rd_chk(1, 8'h08, 32'h0, "R3 pin cause write-0 clear");
    rd_chk(0, 8'h0C, 32'h00000005, "R5 summary drops with pin cause");

    // R5 top slice
    pulse(32'h0, 32'h0, 32'h80000000);
    wr(1, 8'h0C, 32'hFFFFFFFF);
    rd_chk(0, 8'h0C, 32'h08000005, "R5 summary bit 27");
    wr(1, 8'h08, 32'h0);
    wr(0, 8'h0C, 32'h0);

    // R9 unmapped and select writes
    wr(0, 8'h08, 32'hFFFFFFFF);
    rd_chk(0, 8'h08, 32'h0, "R9 unmapped main read");
    wr(1, 8'h14, 32'hFFFFFFFF);
    rd_chk(0, 8'h14, 32'h00000001, "R9 pin-window stray write");
    wr(0, 8'h24, 32'hFFFFFFFF);
    rd_chk(0, 8'h24, 32'h40000000, "R9 select write ignored");
    rd_chk(1, 8'h04, 32'h0, "R9 unmapped pin read");
    check(irq === 1'b0, "R9 irq quiet", {31'h0, irq}, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule